// File: doc/BRIEF.md
# Complementary Chopper PWM with Timed Fault Hold

This block generates the two gate commands of a two-leg chopper. A free-running period counter divides the clock into PWM periods of `PERIOD_CYC` cycles: 6250 cycles at a 100 MHz clock gives 16 kHz. The high-side command `c_hi` is asserted while the counter is below the active duty count. The low-side command `c_lo` is its exact logical opposite, and no dead time is inserted between the two.

A processor programs the block through a simple register write port. Address 0 holds the duty count in clock cycles. Address 1 holds the fault-window length in clock cycles. A write to address 2 with data bit 0 set triggers a fault window. During the window both gate commands are held at logic 0, which mimics a controller that has stopped. When the window ends, switching resumes in the same phase, because the period counter keeps running throughout the window.

Top module: `chopper_pwm`

## Requirements
- R1: Whenever no fault window is active, `c_lo` is the logical inverse of `c_hi` in every cycle.
- R2: The period counter steps from 0 to `PERIOD_CYC`-1 and then wraps to 0. `c_hi` is 1 exactly while the counter value is below the active duty count.
- R3: A duty count of 0 keeps `c_hi` at 0 and `c_lo` at 1 for the whole period.
- R4: A duty count at or above `PERIOD_CYC` saturates to `PERIOD_CYC` and keeps `c_hi` at 1 and `c_lo` at 0 for the whole period.
- R5: A duty count written at address 0 takes effect only when the counter wraps from `PERIOD_CYC`-1 to 0. The period in progress finishes with the old value.
- R6: A write to address 2 with `wr_data[0]`=1 forces `c_hi` and `c_lo` to 0 from the next clock edge, for exactly as many cycles as the fault length held at address 1 at the time of that write.
- R7: A trigger during an active window restarts it, and the window then runs for the full fault length counted from the new trigger.
- R8: A trigger while the fault length is 0 has no effect on the outputs.
- R9: The period counter keeps counting during a fault window, so switching after the window is in the same phase as if no fault had occurred.
- R10: After reset the duty count, the fault length and the window are all 0, so `c_hi`=0 and `c_lo`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 duty, 1 fault length, 2 trigger |
| wr_data | input | DATA_W | Write data |
| c_hi | output | 1 | High-side gate command |
| c_lo | output | 1 | Low-side gate command |

## Verification
Every duty count from 0 to two above the period is swept, and each is held for two full periods. This separates the two saturated ends from the ordinary compare, and it shows an off-by-one in the threshold or in the counter wrap. A duty write placed in the middle of a period tells boundary-synchronised loading apart from immediate loading. The fault stimuli are a single window, a retrigger inside a window, a trigger with zero length, and a long window that spans a period boundary. Together they distinguish window length, restart, the no-effect case and counter continuity.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_DUTY = 2'd0,
      REG_FLEN = 2'd1,
      REG_TRIG = 2'd2
   } cpwm_reg_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
   import cpwm_pkg::*;
#(
   parameter int PERIOD_CYC = 6250,
   parameter int FAULT_W    = 16,
   parameter int DATA_W     = 16,
   localparam int DUTY_W    = $clog2(PERIOD_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DUTY_W-1:0] duty_shadow,
   output logic [FAULT_W-1:0] fault_len,
   output logic              trig_pulse
);
   cpwm_reg_e sel;
   assign sel = cpwm_reg_e'(wr_addr);

   // trigger acts in the same cycle as the write strobe
   assign trig_pulse = wr_en && (sel == REG_TRIG) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_shadow <= '0;
         fault_len   <= '0;
      end else if (wr_en) begin
         case (sel)
            REG_DUTY: begin
               if (wr_data > DATA_W'(PERIOD_CYC))
                  duty_shadow <= DUTY_W'(PERIOD_CYC);
               else
                  duty_shadow <= wr_data[DUTY_W-1:0];
            end
            REG_FLEN: fault_len <= wr_data[FAULT_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cpwm_period.sv
module cpwm_period #(
   parameter int PERIOD_CYC = 6250,
   localparam int CNT_W     = $clog2(PERIOD_CYC),
   localparam int DUTY_W    = $clog2(PERIOD_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_shadow,
   output logic [CNT_W-1:0]  cnt,
   output logic [DUTY_W-1:0] duty_act,
   output logic              phase_hi
);
   logic last;
   assign last = (cnt == CNT_W'(PERIOD_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         duty_act <= '0;
      end else begin
         cnt <= last ? '0 : cnt + 1'b1;
         if (last) duty_act <= duty_shadow;
      end
   end

   assign phase_hi = (DUTY_W'(cnt) < duty_act);
endmodule

// File: rtl/cpwm_fault.sv
module cpwm_fault #(
   parameter int FAULT_W      = 16,
   parameter bit ENABLE_FAULT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_pulse,
   input  logic [FAULT_W-1:0] fault_len,
   output logic               fault_act
);
   generate
      if (ENABLE_FAULT) begin : g_timer
         logic [FAULT_W-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)
               remain <= '0;
            else if (trig_pulse)
               remain <= fault_len;
            else if (remain != '0)
               remain <= remain - 1'b1;
         end
         assign fault_act = (remain != '0);
      end else begin : g_none
         assign fault_act = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/chopper_pwm.sv
module chopper_pwm
   import cpwm_pkg::*;
#(
   parameter int PERIOD_CYC   = 6250,
   parameter int FAULT_W      = 16,
   parameter int DATA_W       = 16,
   parameter bit ENABLE_FAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              c_hi,
   output logic              c_lo
);
   localparam int CNT_W  = $clog2(PERIOD_CYC);
   localparam int DUTY_W = $clog2(PERIOD_CYC + 1);

   if (PERIOD_CYC < 2) begin : g_bad_period
      $error("PERIOD_CYC must be at least 2");
   end
   if (DATA_W < DUTY_W || DATA_W < FAULT_W) begin : g_bad_data
      $error("DATA_W too narrow for duty or fault length");
   end
   if (FAULT_W < 1) begin : g_bad_fault
      $error("FAULT_W must be at least 1");
   end

   logic [DUTY_W-1:0]  duty_shadow;
   logic [FAULT_W-1:0] fault_len;
   logic               trig_pulse;
   logic [CNT_W-1:0]   cnt;
   logic [DUTY_W-1:0]  duty_act;
   logic               phase_hi;
   logic               fault_act;

   cpwm_regs #(.PERIOD_CYC(PERIOD_CYC), .FAULT_W(FAULT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .duty_shadow(duty_shadow), .fault_len(fault_len), .trig_pulse(trig_pulse)
   );

   cpwm_period #(.PERIOD_CYC(PERIOD_CYC)) u_period (
      .clk(clk), .rst_n(rst_n), .duty_shadow(duty_shadow),
      .cnt(cnt), .duty_act(duty_act), .phase_hi(phase_hi)
   );

   cpwm_fault #(.FAULT_W(FAULT_W), .ENABLE_FAULT(ENABLE_FAULT)) u_fault (
      .clk(clk), .rst_n(rst_n), .trig_pulse(trig_pulse),
      .fault_len(fault_len), .fault_act(fault_act)
   );

   assign c_hi =  phase_hi & ~fault_act;
   assign c_lo = ~phase_hi & ~fault_act;
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
   parameter int PERIOD_CYC   = 6250,
   parameter int FAULT_W      = 16,
   parameter bit ENABLE_FAULT = 1'b1,
   localparam int CNT_W       = $clog2(PERIOD_CYC),
   localparam int DUTY_W      = $clog2(PERIOD_CYC + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               c_hi,
   input logic               c_lo,
   input logic [CNT_W-1:0]   cnt,
   input logic [DUTY_W-1:0]  duty_act,
   input logic               fault_act,
   input logic               trig_pulse,
   input logic [FAULT_W-1:0] fault_len
);
   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_act |-> (c_hi != c_lo)); // R1
   AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fault_act |-> (!c_hi && !c_lo)); // R6
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(PERIOD_CYC - 1)) |=> (cnt == '0)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_W'(PERIOD_CYC - 1)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R9
   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_W'(PERIOD_CYC - 1)) |=> $stable(duty_act)); // R5
   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> !c_hi); // R3
   AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act >= DUTY_W'(PERIOD_CYC)) |-> !c_lo); // R4
   AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
      (ENABLE_FAULT && trig_pulse && fault_len != '0) |=> fault_act); // R7
   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pulse && fault_len == '0) |=> !fault_act); // R8
endmodule

bind chopper_pwm cpwm_checker #(
   .PERIOD_CYC(PERIOD_CYC), .FAULT_W(FAULT_W), .ENABLE_FAULT(ENABLE_FAULT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .c_hi(c_hi), .c_lo(c_lo), .cnt(cnt),
   .duty_act(duty_act), .fault_act(fault_act), .trig_pulse(trig_pulse),
   .fault_len(fault_len)
);

// File: tb/chopper_pwm_tb.sv
module chopper_pwm_tb;
   localparam int CLK_PERIOD = 10;
   localparam int P      = 20;
   localparam int FW     = 8;
   localparam int DW     = 16;
   localparam int WD_LIM = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic c_hi, c_lo;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit run_chk = 1'b0;
   string cur_req = "R2";

   // bench-side model built from the requirements
   int m_cnt = 0, m_shadow = 0, m_act = 0, m_flen = 0, m_rem = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chopper_pwm #(.PERIOD_CYC(P), .FAULT_W(FW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .c_hi(c_hi), .c_lo(c_lo)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_shadow <= 0; m_act <= 0; m_flen <= 0; m_rem <= 0;
      end else begin
         if (wr_en && wr_addr == 2'd0)
            m_shadow <= (int'(wr_data) > P) ? P : int'(wr_data);
         if (wr_en && wr_addr == 2'd1)
            m_flen <= int'(wr_data[FW-1:0]);
         if (wr_en && wr_addr == 2'd2 && wr_data[0])
            m_rem <= m_flen;
         else if (m_rem != 0)
            m_rem <= m_rem - 1;
         m_cnt <= (m_cnt == P-1) ? 0 : m_cnt + 1;
         if (m_cnt == P-1) m_act <= m_shadow;
      end
   end

   always @(negedge clk) begin
      if (run_chk && rst_n) begin
         logic eh, el;
         string tag;
         eh = (m_cnt < m_act) && (m_rem == 0);
         el = !(m_cnt < m_act) && (m_rem == 0);
         tag = (m_rem != 0) ? "R6" : cur_req;
         n_checks++;
         if (c_hi !== eh || c_lo !== el) begin
            n_fail++;
            $display("FAIL %s: cnt=%0d c_hi/c_lo=%b%b expected %b%b", tag, m_cnt, c_hi, c_lo, eh, el);
         end
         if (m_rem == 0) begin
            n_checks++;
            if (c_hi === c_lo) begin
               n_fail++;
               $display("FAIL R1: c_hi=%b c_lo=%b expected opposite", c_hi, c_lo);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (WD_LIM) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected completion", WD_LIM);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      n_checks++;
      if (c_hi !== 1'b0 || c_lo !== 1'b1) begin
         n_fail++;
         $display("FAIL R10: c_hi/c_lo=%b%b expected 01", c_hi, c_lo);
      end
      run_chk = 1'b1;

      // R2 R3 R4: full duty sweep, two periods each
      for (int d = 0; d <= P + 2; d++) begin
         cur_req = (d == 0) ? "R3" : ((d >= P) ? "R4" : "R2");
         wr(2'd0, d);
         wait_cyc(2 * P);
      end

      // R5: mid-period duty change
      cur_req = "R5";
      wr(2'd0, 3);
      wait_cyc(2 * P);
      while (m_cnt != 5) @(negedge clk);
      wr(2'd0, 15);
      wait_cyc(2 * P);

      // R6: single window
      cur_req = "R6";
      wr(2'd1, 7);
      wr(2'd2, 1);
      wait_cyc(20);

      // R7: retrigger inside a window
      cur_req = "R7";
      wr(2'd2, 1);
      wait_cyc(3);
      wr(2'd2, 1);
      wait_cyc(20);

      // R8: zero-length trigger
      cur_req = "R8";
      wr(2'd1, 0);
      wr(2'd2, 1);
      wait_cyc(10);

      // R9: long window across a period boundary
      cur_req = "R9";
      wr(2'd0, 9);
      wr(2'd1, 33);
      wr(2'd2, 1);
      wait_cyc(3 * P);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule